// File: doc/BRIEF.md
# NAND Page Layout Reorder Engine

This block takes a raw NAND page as it arrives from the flash, one byte per cycle in flash order, and gives every byte the address it should have in a memory buffer. On the flash the page is laid out step by step. Each correction step is stored as its data chunk, then a few free user bytes, then its parity bytes. Whatever is left of the spare area sits at the very end. In the memory buffer every data chunk is packed first. The per-step user and parity pairs follow in step order, and the unused spare bytes go last. Byte values are never changed. Only the write address is computed, from the step index and from the byte's position inside its field.

The byte stream uses valid/ready handshaking on both sides, with one register stage between them. After the final byte of a page has been handed on, a one-cycle done pulse is raised. The next byte accepted after that starts a new page. A separate combinational port reports where the error-correction region of a given section starts inside the spare area, and it rejects section numbers that do not exist. Computing the correction code itself is not part of this block.

The chunk size, step count, user-byte count, parity-byte count and spare size are parameters. The defaults describe a page of 2 KB plus 64 spare bytes, with two 1 KB steps, 2 user bytes and 14 parity bytes per step.

Top module: `nand_page_reorder`

## Requirements
- R1: A data byte at offset o of step s is written to address s*CHUNK_B + o.
- R2: A user byte at offset o of step s is written to address STEPS*CHUNK_B + s*(USER_B+PAR_B) + o.
- R3: A parity byte at offset o of step s is written to address STEPS*CHUNK_B + s*(USER_B+PAR_B) + USER_B + o.
- R4: The unused spare bytes after the last step's parity keep their order and are written from address STEPS*CHUNK_B + STEPS*(USER_B+PAR_B) to the end of the page.
- R5: Every byte leaves with the same value it arrived with, and bytes leave in arrival order.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_data and out_addr hold their values. When out_valid is 0, in_ready is 1.
- R7: page_done is 1 for exactly one cycle. That cycle is the one after the final byte of a page (address PAGE_B-1) is transferred on the output. page_done is 0 at all other times.
- R8: The byte accepted after a page's last byte is treated as data offset 0 of step 0 of a new page, so it goes to address 0.
- R9: For sec_idx below STEPS, sec_ok is 1 and sec_offset equals USER_B + sec_idx*(USER_B+PAR_B), counted from the start of the spare area.
- R10: For sec_idx at or above STEPS, sec_ok is 0 and sec_offset is 0.
- R11: While rst_n is 0, out_valid and page_done are 0 and in_ready is 1. A page that was partly received is dropped, and the next byte after reset goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Page byte in flash order |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Page byte, unchanged |
| out_addr | output | AW | Destination address in the memory buffer |
| page_done | output | 1 | One-cycle pulse after the last byte of a page |
| sec_idx | input | SIW | Section number to look up |
| sec_ok | output | 1 | Section number is in range |
| sec_offset | output | SPW | Start of the section's correction region within the spare area |

## Verification
The bench targets the field boundaries: the last data byte of a step, the first and last user byte, the step-1 boundary, the first unused spare byte and the final byte of the page. A counter that slips by one at any of these boundaries sends a whole field to the wrong address, and the table lookups report it. Two pages are streamed back to back with back-pressure, so the bench also sees a wrapping error (page two not starting at address 0), a stall that drops or repeats a byte, and a done pulse that comes early, comes late or lasts more than one cycle. A reset in the middle of a page checks that the position is cleared. Section numbers just inside and just outside the valid range expose an off-by-one range check or a wrong section stride.

// File: rtl/nand_reorder_pkg.sv
package nand_reorder_pkg;

   // Field of the flash layout that the current byte belongs to
   typedef enum logic [1:0] {
      FLD_DATA = 2'd0,
      FLD_USER = 2'd1,
      FLD_PAR  = 2'd2,
      FLD_TAIL = 2'd3
   } fld_e;

   function automatic int unsigned width_of(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/nrp_position.sv
// Walks the flash layout: step index, field and offset inside the field.
module nrp_position
   import nand_reorder_pkg::*;
#(
   parameter int unsigned STEPS   = 2,
   parameter int unsigned CHUNK_B = 1024,
   parameter int unsigned USER_B  = 2,
   parameter int unsigned PAR_B   = 14,
   parameter int unsigned TAIL_B  = 32,
   parameter int unsigned SW      = 1,
   parameter int unsigned OW      = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [SW-1:0] step,
   output fld_e          fld,
   output logic [OW-1:0] off,
   output logic          page_last
);

   localparam logic [OW-1:0] CHUNK_END = OW'(CHUNK_B - 1);
   localparam logic [OW-1:0] USER_END  = OW'(USER_B - 1);
   localparam logic [OW-1:0] PAR_END   = OW'(PAR_B - 1);
   localparam logic [OW-1:0] TAIL_END  = OW'((TAIL_B > 0) ? TAIL_B - 1 : 0);
   localparam logic [SW-1:0] STEP_END  = SW'(STEPS - 1);

   logic [SW-1:0] nxt_step;
   fld_e          nxt_fld;
   logic [OW-1:0] nxt_off;
   fld_e          after_par;

   // Variant: with no spare tail the page wraps straight after the last parity byte
   generate
      if (TAIL_B > 0) begin : g_tail
         assign after_par = FLD_TAIL;
         assign page_last = (fld == FLD_TAIL) && (off == TAIL_END);
      end else begin : g_no_tail
         assign after_par = FLD_DATA;
         assign page_last = (fld == FLD_PAR) && (step == STEP_END) && (off == PAR_END);
      end
   endgenerate

   always_comb begin
      nxt_step = step;
      nxt_fld  = fld;
      nxt_off  = off + 1'b1;
      unique case (fld)
         FLD_DATA: begin
            if (off == CHUNK_END) begin
               nxt_fld = FLD_USER;
               nxt_off = '0;
            end
         end
         FLD_USER: begin
            if (off == USER_END) begin
               nxt_fld = FLD_PAR;
               nxt_off = '0;
            end
         end
         FLD_PAR: begin
            if (off == PAR_END) begin
               nxt_off = '0;
               if (step == STEP_END) begin
                  nxt_step = '0;
                  nxt_fld  = after_par;
               end else begin
                  nxt_step = step + 1'b1;
                  nxt_fld  = FLD_DATA;
               end
            end
         end
         default: begin
            if (off == TAIL_END) begin
               nxt_step = '0;
               nxt_fld  = FLD_DATA;
               nxt_off  = '0;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step <= '0;
         fld  <= FLD_DATA;
         off  <= '0;
      end else if (adv) begin
         step <= nxt_step;
         fld  <= nxt_fld;
         off  <= nxt_off;
      end
   end

endmodule

// File: rtl/nrp_addr_gen.sv
// Maps (step, field, offset) to the memory-side write address.
module nrp_addr_gen
   import nand_reorder_pkg::*;
#(
   parameter int unsigned STEPS   = 2,
   parameter int unsigned CHUNK_B = 1024,
   parameter int unsigned USER_B  = 2,
   parameter int unsigned PAR_B   = 14,
   parameter int unsigned SW      = 1,
   parameter int unsigned OW      = 10,
   parameter int unsigned AW      = 12
) (
   input  logic [SW-1:0] step,
   input  fld_e          fld,
   input  logic [OW-1:0] off,
   output logic [AW-1:0] addr
);

   localparam int unsigned PAIR_B   = USER_B + PAR_B;
   localparam logic [AW-1:0] SPARE0 = AW'(STEPS * CHUNK_B);
   localparam logic [AW-1:0] TAIL0  = AW'(STEPS * CHUNK_B + STEPS * PAIR_B);
   localparam logic [AW-1:0] USER_A = AW'(USER_B);

   logic [AW-1:0] data_base;
   logic [AW-1:0] pair_base;
   logic [AW-1:0] off_w;

   assign off_w = AW'(off);

   // Variant: power-of-two chunks place the step index by shifting
   generate
      if ((CHUNK_B & (CHUNK_B - 1)) == 0) begin : g_shift
         assign data_base = AW'(step) << $clog2(CHUNK_B);
      end else begin : g_mult
         assign data_base = AW'(step) * AW'(CHUNK_B);
      end
   endgenerate

   assign pair_base = SPARE0 + AW'(step) * AW'(PAIR_B);

   always_comb begin
      unique case (fld)
         FLD_DATA: addr = data_base + off_w;
         FLD_USER: addr = pair_base + off_w;
         FLD_PAR:  addr = pair_base + USER_A + off_w;
         default:  addr = TAIL0 + off_w;
      endcase
   end

endmodule

// File: rtl/nrp_sec_offset.sv
// Start of a section's correction region inside the spare area.
module nrp_sec_offset #(
   parameter int unsigned STEPS  = 2,
   parameter int unsigned USER_B = 2,
   parameter int unsigned PAR_B  = 14,
   parameter int unsigned SIW    = 2,
   parameter int unsigned SPW    = 6
) (
   input  logic [SIW-1:0] sec_idx,
   output logic           sec_ok,
   output logic [SPW-1:0] sec_offset
);

   localparam int unsigned PAIR_B = USER_B + PAR_B;
   localparam int unsigned XW     = SIW + SPW;

   logic [XW-1:0] span;

   assign sec_ok = (XW'(sec_idx) < XW'(STEPS));
   assign span   = XW'(USER_B) + XW'(sec_idx) * XW'(PAIR_B);

   always_comb begin
      if (sec_ok) sec_offset = span[SPW-1:0];
      else        sec_offset = '0;
   end

endmodule

// File: rtl/nand_page_reorder.sv
module nand_page_reorder
   import nand_reorder_pkg::*;
#(
   parameter  int unsigned STEPS   = 2,
   parameter  int unsigned CHUNK_B = 1024,
   parameter  int unsigned USER_B  = 2,
   parameter  int unsigned PAR_B   = 14,
   parameter  int unsigned SPARE_B = 64,
   localparam int unsigned PAGE_B  = STEPS * CHUNK_B + SPARE_B,
   localparam int unsigned AW      = width_of(PAGE_B),
   localparam int unsigned SW      = width_of(STEPS),
   localparam int unsigned SIW     = SW + 1,
   localparam int unsigned SPW     = width_of(SPARE_B)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [7:0]     in_data,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [7:0]     out_data,
   output logic [AW-1:0]  out_addr,
   output logic           page_done,
   input  logic [SIW-1:0] sec_idx,
   output logic           sec_ok,
   output logic [SPW-1:0] sec_offset
);

   localparam int unsigned PAIR_B = USER_B + PAR_B;
   localparam int unsigned TAIL_B = SPARE_B - STEPS * PAIR_B;
   localparam int unsigned MAXF_A = (CHUNK_B > PAR_B) ? CHUNK_B : PAR_B;
   localparam int unsigned MAXF_B = (USER_B > TAIL_B) ? USER_B : TAIL_B;
   localparam int unsigned MAXF   = (MAXF_A > MAXF_B) ? MAXF_A : MAXF_B;
   localparam int unsigned OW     = width_of(MAXF);

   // Elaboration-time parameter checks
   generate
      if (STEPS < 1)   begin : g_bad_steps  $error("STEPS must be at least 1"); end
      if (CHUNK_B < 1) begin : g_bad_chunk  $error("CHUNK_B must be at least 1"); end
      if (USER_B < 1)  begin : g_bad_user   $error("USER_B must be at least 1"); end
      if (PAR_B < 1)   begin : g_bad_par    $error("PAR_B must be at least 1"); end
      if (SPARE_B < STEPS * PAIR_B) begin : g_bad_spare
         $error("SPARE_B too small for user and parity bytes of all steps");
      end
   endgenerate

   logic [SW-1:0] cur_step;
   fld_e          cur_fld;
   logic [OW-1:0] cur_off;
   logic          cur_last;
   logic [AW-1:0] cur_addr;
   logic          accept;
   logic          out_last;

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   nrp_position #(
      .STEPS(STEPS), .CHUNK_B(CHUNK_B), .USER_B(USER_B), .PAR_B(PAR_B),
      .TAIL_B(TAIL_B), .SW(SW), .OW(OW)
   ) u_pos (
      .clk(clk), .rst_n(rst_n), .adv(accept),
      .step(cur_step), .fld(cur_fld), .off(cur_off), .page_last(cur_last)
   );

   nrp_addr_gen #(
      .STEPS(STEPS), .CHUNK_B(CHUNK_B), .USER_B(USER_B), .PAR_B(PAR_B),
      .SW(SW), .OW(OW), .AW(AW)
   ) u_addr (
      .step(cur_step), .fld(cur_fld), .off(cur_off), .addr(cur_addr)
   );

   nrp_sec_offset #(
      .STEPS(STEPS), .USER_B(USER_B), .PAR_B(PAR_B), .SIW(SIW), .SPW(SPW)
   ) u_sec (
      .sec_idx(sec_idx), .sec_ok(sec_ok), .sec_offset(sec_offset)
   );

   // Single output register stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_addr  <= '0;
         out_last  <= 1'b0;
         page_done <= 1'b0;
      end else begin
         page_done <= out_valid && out_ready && out_last;
         if (accept) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
            out_addr  <= cur_addr;
            out_last  <= cur_last;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nrp_checker.sv
module nrp_checker #(
   parameter int unsigned PAGE_B  = 2112,
   parameter int unsigned SPARE_B = 64,
   parameter int unsigned AW      = 12,
   parameter int unsigned SPW     = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_ready,
   input logic           out_valid,
   input logic           out_ready,
   input logic [7:0]     out_data,
   input logic [AW-1:0]  out_addr,
   input logic           page_done,
   input logic           sec_ok,
   input logic [SPW-1:0] sec_offset
);

   localparam logic [AW-1:0] LAST_A = AW'(PAGE_B - 1);

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));

   p_ready_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   p_addr_in_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_addr <= LAST_A));

   p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      page_done |-> $past(out_valid && out_ready && (out_addr == LAST_A)));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      page_done |=> !page_done);

   p_sec_in_spare_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sec_ok |-> (int'(sec_offset) < int'(SPARE_B)));

   p_sec_reject_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_ok |-> (sec_offset == '0));

endmodule

bind nand_page_reorder nrp_checker #(
   .PAGE_B(PAGE_B), .SPARE_B(SPARE_B), .AW(AW), .SPW(SPW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr),
   .page_done(page_done), .sec_ok(sec_ok), .sec_offset(sec_offset)
);

// File: tb/tb_nand_page_reorder.sv
`timescale 1ns/100ps
module tb_nand_page_reorder;

   localparam int STEPS  = 2;
   localparam int CHUNK  = 1024;
   localparam int USER   = 2;
   localparam int PAR    = 14;
   localparam int SPARE  = 64;
   localparam int PAGE   = STEPS * CHUNK + SPARE;
   localparam int PAIR   = USER + PAR;
   localparam int SPAN   = CHUNK + PAIR;
   localparam int AW     = 12;
   localparam int SIW    = 2;
   localparam int SPW    = 6;

   // flash index, expected address, requirement
   localparam int NTBL = 15;
   localparam int TBL [0:NTBL-1][0:2] = '{
      '{0, 0, 1}, '{1023, 1023, 1}, '{1040, 1024, 1}, '{1500, 1484, 1},
      '{2063, 2047, 1}, '{1024, 2048, 2}, '{1025, 2049, 2}, '{2064, 2064, 2},
      '{1026, 2050, 3}, '{1039, 2063, 3}, '{2066, 2066, 3}, '{2079, 2079, 3},
      '{2080, 2080, 4}, '{2095, 2095, 4}, '{2111, 2111, 4}
   };

   logic           clk = 0;
   logic           rst_n = 0;
   logic           in_valid = 0;
   logic           in_ready;
   logic [7:0]     in_data = 0;
   logic           out_valid;
   logic           out_ready = 1;
   logic [7:0]     out_data;
   logic [AW-1:0]  out_addr;
   logic           page_done;
   logic [SIW-1:0] sec_idx = 0;
   logic           sec_ok;
   logic [SPW-1:0] sec_offset;

   int checks = 0;
   int errors = 0;
   int cap [0:PAGE-1];

   always #2 clk = ~clk;

   nand_page_reorder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_addr(out_addr), .page_done(page_done),
      .sec_idx(sec_idx), .sec_ok(sec_ok), .sec_offset(sec_offset)
   );

   function automatic int ref_addr(input int i);
      int s;
      int r;
      if (i >= STEPS * SPAN) return STEPS * CHUNK + STEPS * PAIR + (i - STEPS * SPAN);
      s = i / SPAN;
      r = i % SPAN;
      if (r < CHUNK) return s * CHUNK + r;
      if (r < CHUNK + USER) return STEPS * CHUNK + s * PAIR + (r - CHUNK);
      return STEPS * CHUNK + s * PAIR + USER + (r - CHUNK - USER);
   endfunction

   function automatic logic [7:0] pat(input int k, input int seed);
      return 8'((k * 13) ^ (k >> 8) ^ seed);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Streams npg pages with the given stall mode; checks every byte.
   task automatic run_pages(input int npg, input int seed, input int mode);
      int  total = npg * PAGE;
      int  sent = 0;
      int  recvd = 0;
      int  cyc = 0;
      bit  exp_done = 0;
      bit  held = 0;
      int  hd = 0;
      int  ha = 0;
      while (recvd < total) begin
         @(negedge clk);
         check(page_done == exp_done, "R7", "page_done", int'(page_done), int'(exp_done));
         exp_done = 0;
         if (held) begin
            check(out_valid == 1'b1 && int'(out_data) == hd && int'(out_addr) == ha,
                  "R6", "stalled output held (addr)", int'(out_addr), ha);
         end
         held = 0;
         out_ready = (mode == 0) ? 1'b1 : ((cyc % 5) != 2 && (cyc % 11) != 4);
         in_valid  = (sent < total) && (((cyc * 3 + seed) % 7) != 0);
         in_data   = pat(sent, seed);
         #0.2;
         if (out_valid && !out_ready) begin
            held = 1;
            hd = int'(out_data);
            ha = int'(out_addr);
            check(in_ready == 1'b0, "R6", "in_ready during stall", int'(in_ready), 0);
         end
         if (out_valid && out_ready) begin
            int idx = recvd % PAGE;
            // R1 R2 R3 R4 R8: address from field position, page wraps to address 0
            check(int'(out_addr) == ref_addr(idx), "R1/R2/R3/R4/R8", "out_addr",
                  int'(out_addr), ref_addr(idx));
            // R5: value and order unchanged
            check(out_data == pat(recvd, seed), "R5", "out_data",
                  int'(out_data), int'(pat(recvd, seed)));
            if (recvd < PAGE) cap[idx] = int'(out_addr);
            if (idx == PAGE - 1) exp_done = 1;
            recvd++;
         end
         if (in_valid && in_ready) sent++;
         cyc++;
      end
      @(negedge clk);
      in_valid = 0;
      out_ready = 1;
      check(page_done == exp_done, "R7", "final page_done", int'(page_done), int'(exp_done));
      @(negedge clk);
      check(page_done == 1'b0, "R7", "page_done one cycle", int'(page_done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog: cycles %0d expected below %0d", 150000, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
      check(page_done == 1'b0, "R11", "page_done in reset", int'(page_done), 0);
      check(in_ready == 1'b1, "R11", "in_ready in reset", int'(in_ready), 1);
      rst_n = 1;

      // Page 1 without back-pressure, page 2 and 3 with stalls
      run_pages(1, 5, 0);
      for (int t = 0; t < NTBL; t++) begin
         check(cap[TBL[t][0]] == TBL[t][1], $sformatf("R%0d", TBL[t][2]),
               $sformatf("table address for flash byte %0d", TBL[t][0]),
               cap[TBL[t][0]], TBL[t][1]);
      end
      run_pages(2, 99, 1);

      // R11: reset in the middle of a page clears the position
      for (int b = 0; b < 5; b++) begin
         @(negedge clk);
         in_valid = 1;
         in_data = 8'(b + 40);
      end
      @(negedge clk);
      in_valid = 0;
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      check(out_valid == 1'b0 && in_ready == 1'b1, "R11", "mid-page reset outputs",
            int'(out_valid), 0);
      rst_n = 1;
      in_valid = 1;
      in_data = 8'hA5;
      @(negedge clk);
      in_valid = 0;
      check(out_valid == 1'b1 && out_addr == '0, "R11", "first byte after reset addr",
            int'(out_addr), 0);
      check(out_data == 8'hA5, "R5", "first byte after reset data", int'(out_data), 165);
      @(negedge clk);

      // R9 and R10: section region offsets
      for (int s = 0; s < 4; s++) begin
         sec_idx = SIW'(s);
         #0.5;
         if (s < STEPS) begin
            check(sec_ok == 1'b1, "R9", $sformatf("sec_ok section %0d", s), int'(sec_ok), 1);
            check(int'(sec_offset) == USER + s * PAIR, "R9",
                  $sformatf("sec_offset section %0d", s), int'(sec_offset), USER + s * PAIR);
         end else begin
            check(sec_ok == 1'b0, "R10", $sformatf("sec_ok section %0d", s), int'(sec_ok), 0);
            check(sec_offset == '0, "R10", $sformatf("sec_offset section %0d", s),
                  int'(sec_offset), 0);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule